// File: doc/BRIEF.md
# Prioritised interrupt pending controller

This block keeps an 8-bit set of pending interrupt requests for a small processor core. At each instruction boundary it decides whether the core must enter a non-maskable or a maskable service routine. Interrupt sources post requests by OR-ing a mask into the pending set. Software withdraws requests with an AND-NOT clear mask. A rising edge on the non-maskable line posts the non-maskable request.

At a boundary the non-maskable request always wins. When it is present, it is accepted and only its own bit is dropped. Otherwise, if any request under the maskable mask is pending, the second one-shot bit is discarded. The maskable request is then accepted only if the core's interrupt-disable flag is clear and the opcode being fetched is not the return-from-interrupt instruction. On acceptance the first one-shot bit is also dropped. The block reports each acceptance as a pulse, together with the address of the service vector. The stack and vector-fetch sequencing of the core lie outside this block.

Top module: `intr_arbiter`

## Requirements
- R1: After reset the pending set is 0x00, both take pulses are low and the vector output reads 0xFFFC, the reset vector.
- R2: A set strobe vector `req_set` ORs into the pending set at the next clock edge. The bit meanings are: bit0 non-maskable, bit1 generic, bit2 frame, bit3 sample-DMA, bit4 mapper, bit5 mapper-2, bit6 one-shot A, bit7 one-shot B.
- R3: `req_clr` removes the bits it has set at the next edge. If a bit is set and cleared in the same cycle, including a clear caused by an acceptance, the set wins.
- R4: A rising edge on `nmi_line` sets bit0 one edge after the high level is first sampled. Holding the line high does not set the bit again.
- R5: At a boundary with bit0 pending, `take_nmi` pulses in the next cycle and only bit0 is cleared. The disable flag and the opcode have no effect on this.
- R6: At a boundary with bit0 clear and at least one bit under mask 0xFC pending, `take_irq` pulses in the next cycle, but only if `irq_disable` is 0 and `opcode` is not 0x40. Bit1 alone never causes an acceptance.
- R7: At a boundary with bit0 clear and at least one bit under 0xFC pending, bit7 is cleared whether or not the maskable request is accepted.
- R8: On a maskable acceptance bit6 is cleared. Bits 1 to 5 are never cleared by an acceptance.
- R9: The vector output changes in the same cycle as a take pulse, to 0xFFFA for non-maskable or 0xFFFE for maskable. It holds that value until the next acceptance.
- R10: A take pulse appears only in the cycle after a boundary, and the two pulses are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_set | input | 8 | Per-source set strobes (OR mask) |
| req_clr | input | 8 | Clear mask (AND-NOT) |
| nmi_line | input | 1 | Non-maskable request line, edge sensitive |
| irq_disable | input | 1 | Core interrupt-disable flag |
| opcode | input | 8 | Opcode being fetched at the boundary |
| insn_bnd | input | 1 | Instruction-boundary strobe |
| pending | output | 8 | Current pending set |
| take_nmi | output | 1 | Non-maskable acceptance pulse |
| take_irq | output | 1 | Maskable acceptance pulse |
| vector | output | 16 | Service vector address |

## Verification
Every one of the 256 pending patterns is loaded and then presented at a boundary, under both values of the disable flag and with both the return opcode and an ordinary opcode. This tells apart the priority of the non-maskable bit, the mask that excludes bit1, and the separate clearing of the two one-shot bits for accepted and blocked requests. Directed sequences drive the non-maskable line high and hold it there, to separate edge detection from level detection. They also apply a set and a clear, or a set and an acceptance, to the same bit in one cycle, to show that the set wins.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int unsigned PEND_W   = 8;
  localparam int unsigned NMI_B    = 0;
  localparam int unsigned OS_A_B   = 6;
  localparam int unsigned OS_B_B   = 7;
  localparam logic [PEND_W-1:0] MASKABLE = 8'hFC;
  localparam logic [15:0] VEC_NMI  = 16'hFFFA;
  localparam logic [15:0] VEC_RST  = 16'hFFFC;
  localparam logic [15:0] VEC_IRQ  = 16'hFFFE;
endpackage

// File: rtl/intr_edge.sv
module intr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic rise_o
);
  logic line_q;
  logic line_d;

  always_comb begin
    line_d = line_i;
    rise_o = line_i & ~line_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b0;
    else        line_q <= line_d;
  end
endmodule

// File: rtl/intr_pend.sv
module intr_pend #(
  parameter int unsigned W = intr_pkg::PEND_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] ack_clr_i,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] pend_q;
  logic [W-1:0] pend_d;
  logic         pend_en;

  always_comb begin
    pend_d  = (pend_q & ~(clr_i | ack_clr_i)) | set_i;
    pend_en = (pend_d != pend_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  // R3
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((pend_q & $past(set_i)) == $past(set_i)));

  // R3
  clr_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i != '0) |=> ((pend_q & $past(clr_i) & ~$past(set_i)) == '0));
endmodule

// File: rtl/intr_decide.sv
module intr_decide #(
  parameter int unsigned W          = intr_pkg::PEND_W,
  parameter logic [7:0]  RTI_OPCODE = 8'h40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pend_i,
  input  logic         bnd_i,
  input  logic         idis_i,
  input  logic [7:0]   opcode_i,
  output logic [W-1:0] ack_clr_o,
  output logic         take_nmi_o,
  output logic         take_irq_o,
  output logic [15:0]  vector_o
);
  import intr_pkg::*;

  logic        nmi_hit;
  logic        mask_hit;
  logic        irq_ok;
  logic        tn_q, ti_q;
  logic [15:0] vec_q, vec_d;
  logic        vec_en;

  always_comb begin
    nmi_hit  = bnd_i & pend_i[NMI_B];
    mask_hit = bnd_i & ~pend_i[NMI_B] & (|(pend_i & MASKABLE));
    irq_ok   = mask_hit & ~idis_i & (opcode_i != RTI_OPCODE);
    ack_clr_o         = '0;
    ack_clr_o[NMI_B]  = nmi_hit;
    ack_clr_o[OS_B_B] = mask_hit;
    ack_clr_o[OS_A_B] = irq_ok;
    vec_en = nmi_hit | irq_ok;
    vec_d  = nmi_hit ? VEC_NMI : VEC_IRQ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tn_q <= 1'b0;
      ti_q <= 1'b0;
    end else begin
      tn_q <= nmi_hit;
      ti_q <= irq_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vec_q <= VEC_RST;
    else if (vec_en) vec_q <= vec_d;
  end

  assign take_nmi_o = tn_q;
  assign take_irq_o = ti_q;
  assign vector_o   = vec_q;

  // R10
  excl_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(take_nmi_o && take_irq_o));

  // R10
  take_after_bnd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_nmi_o || take_irq_o) |-> $past(bnd_i));

  // R5
  nmi_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bnd_i && pend_i[NMI_B]) |=> (take_nmi_o && !take_irq_o));

  // R6
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq_o |-> $past(!idis_i && opcode_i != RTI_OPCODE && !pend_i[NMI_B]));

  // R9
  vec_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_nmi_o |-> (vector_o == VEC_NMI));

  // R9
  vec_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq_o |-> (vector_o == VEC_IRQ));

  // R9
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_nmi_o && !take_irq_o) |-> $stable(vector_o));
endmodule

// File: rtl/intr_arbiter.sv
module intr_arbiter #(
  parameter logic [7:0] RTI_OPCODE = 8'h40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  req_set,
  input  logic [7:0]  req_clr,
  input  logic        nmi_line,
  input  logic        irq_disable,
  input  logic [7:0]  opcode,
  input  logic        insn_bnd,
  output logic [7:0]  pending,
  output logic        take_nmi,
  output logic        take_irq,
  output logic [15:0] vector
);
  import intr_pkg::*;

  logic              nmi_rise;
  logic [PEND_W-1:0] set_all;
  logic [PEND_W-1:0] ack_clr;
  logic [PEND_W-1:0] pend;

  intr_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_i (nmi_line),
    .rise_o (nmi_rise)
  );

  always_comb begin
    set_all        = req_set;
    set_all[NMI_B] = req_set[NMI_B] | nmi_rise;
  end

  intr_pend #(.W(PEND_W)) u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (set_all),
    .clr_i     (req_clr),
    .ack_clr_i (ack_clr),
    .pend_o    (pend)
  );

  intr_decide #(.W(PEND_W), .RTI_OPCODE(RTI_OPCODE)) u_decide (
    .clk        (clk),
    .rst_n      (rst_n),
    .pend_i     (pend),
    .bnd_i      (insn_bnd),
    .idis_i     (irq_disable),
    .opcode_i   (opcode),
    .ack_clr_o  (ack_clr),
    .take_nmi_o (take_nmi),
    .take_irq_o (take_irq),
    .vector_o   (vector)
  );

  assign pending = pend;

  // R4
  nmi_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_line && !$past(nmi_line)) |=> pending[NMI_B]);
endmodule

// File: tb/intr_arbiter_tb.sv
`timescale 1ns/1ps
module intr_arbiter_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  req_set, req_clr, opcode;
  logic        nmi_line, irq_disable, insn_bnd;
  logic [7:0]  pending;
  logic        take_nmi, take_irq;
  logic [15:0] vector;

  int total = 0;
  int bad = 0;
  logic [15:0] exp_vec;

  always #2.5 clk = ~clk;

  intr_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .req_set(req_set), .req_clr(req_clr),
    .nmi_line(nmi_line), .irq_disable(irq_disable), .opcode(opcode),
    .insn_bnd(insn_bnd), .pending(pending), .take_nmi(take_nmi),
    .take_irq(take_irq), .vector(vector)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] s, input logic [7:0] c, input logic n,
                      input logic b, input logic f, input logic [7:0] op);
    @(negedge clk);
    req_set = s; req_clr = c; nmi_line = n; insn_bnd = b; irq_disable = f; opcode = op;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_set = 0; req_clr = 0; nmi_line = 0; irq_disable = 0;
    opcode = 8'hEA; insn_bnd = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1
    chk("R1 pending", pending, 8'h00);
    chk("R1 take_nmi", take_nmi, 1'b0);
    chk("R1 take_irq", take_irq, 1'b0);
    chk("R1 vector", vector, 16'hFFFC);
    @(negedge clk); rst_n = 1'b1;
    exp_vec = 16'hFFFC;

    // Sweep every pending pattern against disable flag and opcode kind
    for (int p = 0; p < 256; p++) begin
      for (int f = 0; f < 2; f++) begin
        for (int o = 0; o < 2; o++) begin
          logic [7:0] op, ep;
          logic en, ei;
          op = (o != 0) ? 8'h40 : 8'hA9;
          step(p[7:0], 8'hFF, 1'b0, 1'b0, f[0], op);
          chk("R2 load", pending, p[7:0]);
          en = p[0];
          ei = 1'b0;
          ep = p[7:0];
          if (p[0]) begin
            ep = ep & 8'hFE;
            exp_vec = 16'hFFFA;
          end else if ((p[7:0] & 8'hFC) != 0) begin
            ep = ep & 8'h7F;
            if (f == 0 && o == 0) begin
              ei = 1'b1;
              ep = ep & 8'hBF;
              exp_vec = 16'hFFFE;
            end
          end
          step(8'h00, 8'h00, 1'b0, 1'b1, f[0], op);
          chk("R5 take_nmi", take_nmi, en);
          chk("R6 take_irq", take_irq, ei);
          chk("R7 R8 pending after boundary", pending, ep);
          chk("R9 vector", vector, exp_vec);
          step(8'h00, 8'h00, 1'b0, 1'b0, f[0], op);
          chk("R10 no pulse without boundary", {take_nmi, take_irq}, 2'b00);
          chk("R9 vector hold", vector, exp_vec);
        end
      end
    end

    // R3: set and clear of same bit, set wins; AND-NOT clear
    step(8'h00, 8'hFF, 0, 0, 0, 8'hEA);
    step(8'hF0, 8'h00, 0, 0, 0, 8'hEA);
    step(8'h10, 8'h30, 0, 0, 0, 8'hEA);
    chk("R3 collision and and-not", pending, 8'hD0);
    // R3: set wins over acceptance clear of bit6
    step(8'h00, 8'hFF, 0, 0, 0, 8'hEA);
    step(8'h40, 8'h00, 0, 0, 0, 8'hEA);
    step(8'h40, 8'h00, 0, 1, 0, 8'hEA);
    chk("R3 set beats accept clear take", take_irq, 1'b1);
    chk("R3 set beats accept clear pending", pending, 8'h40);

    // R4: edge on nmi_line
    step(8'h00, 8'hFF, 0, 0, 1, 8'hEA);
    step(8'h00, 8'h00, 1, 0, 1, 8'hEA);
    chk("R4 rise sets bit0", pending, 8'h01);
    step(8'h00, 8'h01, 1, 0, 1, 8'hEA);
    step(8'h00, 8'h00, 1, 0, 1, 8'hEA);
    chk("R4 level does not re-set", pending, 8'h00);
    step(8'h00, 8'h00, 0, 0, 1, 8'hEA);
    step(8'h00, 8'h00, 1, 0, 1, 8'hEA);
    chk("R4 second rise sets", pending, 8'h01);
    // R5: NMI taken despite disable flag and RTI opcode, other bits kept
    step(8'h3E, 8'h00, 1, 0, 1, 8'h40);
    step(8'h00, 8'h00, 1, 1, 1, 8'h40);
    chk("R5 nmi under mask", take_nmi, 1'b1);
    chk("R5 only bit0 cleared", pending, 8'h3E);
    chk("R9 nmi vector", vector, 16'hFFFA);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule